// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit packed-integer arithmetic unit for a media datapath. One operand word is read either as eight unsigned byte lanes or as four signed halfword lanes, and every lane is processed in parallel. The second operand can be the full second vector, one lane of that vector copied to all lanes, or a 5-bit immediate copied to all lanes. The operations are bitwise logic, shifts, saturating add, subtract and multiply, min and max, a halfword sign-multiply, and a byte average and absolute difference.

The data result is combinational, so a pipeline stage around the unit can register it where it fits best. A compare operation writes one flag per lane into an 8-bit condition register on the clock edge. A later pick operation reads those flags and merges the two operands lane by lane. When an opcode has no meaning in the chosen lane format, the unit raises an illegal flag, drives a zero result and leaves the condition register unchanged.

Top module: `simd_sat_alu`

## Requirements
- R1: `fmtsel[0]` picks the lane format. 0 gives eight unsigned byte lanes and 1 gives four signed halfword lanes. Lane 0 occupies the least significant bits. Min (code 8) and max (code 9) compare bytes unsigned and halfwords signed.
- R2: `fmtsel[4:3]` picks the second operand. 2'b10 uses `opb` as a full vector. 2'b11 zero-extends `imm` and copies it to every lane. When `fmtsel[4]` is 0, one lane of `opb` is copied to every lane: the lane index is `fmtsel[3:1]` for bytes and `fmtsel[3:2]` for halfwords.
- R3: The bitwise codes are AND (0), NOR (1), OR (2) and XOR (3).
- R4: Shift-left logical (4) and shift-right logical (5) use the low 3 bits of the second-operand lane as the count for bytes, and the low 4 bits for halfwords. Shift-right arithmetic (12) exists for halfwords only.
- R5: Add (6) and subtract (7) saturate. Byte results clamp to 0..255 and halfword results clamp to -32768..32767.
- R6: Multiply (10) saturates to the same per-format ranges.
- R7: Sign-multiply (11) exists for halfwords only. It returns the negated first-operand lane when the second lane is negative, and otherwise returns the first lane unchanged. Negating -32768 gives 32767.
- R8: Average (14) gives (a+b+1)>>1 and absolute difference (13) gives |a-b|. Both exist for bytes only.
- R9: Compare (15) drives a zero result. On a clock edge with `op_en` high, it writes flag i = (`cmp_eq` and a==b) or (`cmp_lt` and a<b) into `cond_q`. The less-than test is unsigned for bytes and signed for halfwords.
- R10: A halfword compare writes only `cond_q[3:0]`. `cond_q[7:4]` keeps its value.
- R11: Pick (16) returns lane i of `opa` when `cond_q[i]` equals `pick_tf`, and otherwise returns lane i of the second operand.
- R12: These opcodes are illegal: codes 17..31; codes 11 and 12 with byte lanes; codes 13 and 14 with halfword lanes. An illegal opcode raises `illegal`, drives `result` to zero and leaves `cond_q` unchanged.
- R13: Reset clears `cond_q`. `cond_q` changes only on a legal compare with `op_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Allows a compare to update the condition register |
| opcode | input | 5 | Operation code |
| fmtsel | input | 5 | Lane format and second-operand source |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand vector |
| imm | input | 5 | Immediate second operand |
| cmp_eq | input | 1 | Compare tests equality |
| cmp_lt | input | 1 | Compare tests less-than |
| pick_tf | input | 1 | Flag value that selects `opa` in a pick |
| result | output | 64 | Packed result |
| cond_q | output | 8 | Condition register, one bit per lane |
| illegal | output | 1 | Opcode undefined for the chosen format |

## Verification
The block has no parameters, so the bench builds its one fixed 64-bit configuration. That configuration covers every lane of both formats. The bench drives the clamp limits on each format, and the -32768 cases of multiply and sign-multiply. It uses the same bit patterns under both signedness rules. It builds the condition register with a byte compare and then a halfword compare, so that a pick must honour both the retained upper flags and the rewritten lower flags.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_en,
  input  logic [4:0]  opcode,
  input  logic [4:0]  fmtsel,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic [4:0]  imm,
  input  logic        cmp_eq,
  input  logic        cmp_lt,
  input  logic        pick_tf,
  output logic [63:0] result,
  output logic [7:0]  cond_q,
  output logic        illegal
);
  localparam logic [4:0] OP_AND = 5'd0, OP_NOR = 5'd1, OP_OR = 5'd2, OP_XOR = 5'd3;
  localparam logic [4:0] OP_SLL = 5'd4, OP_SRL = 5'd5, OP_ADD = 5'd6, OP_SUB = 5'd7;
  localparam logic [4:0] OP_MIN = 5'd8, OP_MAX = 5'd9, OP_MUL = 5'd10, OP_SMUL = 5'd11;
  localparam logic [4:0] OP_SRA = 5'd12, OP_ABSD = 5'd13, OP_AVG = 5'd14;
  localparam logic [4:0] OP_CMP = 5'd15, OP_PICK = 5'd16;

  logic        half;
  logic [7:0]  elem_b;
  logic [15:0] elem_h;
  logic [63:0] src_b, src_h, res_b, res_h;
  logic [7:0]  flag_b;
  logic [3:0]  flag_h;

  assign half   = fmtsel[0];
  assign elem_b = 8'(opb >> {fmtsel[3:1], 3'd0});
  assign elem_h = 16'(opb >> {fmtsel[3:2], 4'd0});

  always_comb begin
    if (!fmtsel[4]) begin
      src_b = {8{elem_b}};
      src_h = {4{elem_h}};
    end else if (!fmtsel[3]) begin
      src_b = opb;
      src_h = opb;
    end else begin
      src_b = {8{3'd0, imm}};
      src_h = {4{11'd0, imm}};
    end
  end

  for (genvar i = 0; i < 8; i++) begin : g_byte
    logic [7:0]  a, b, r;
    logic [8:0]  s, d, s1;
    logic [15:0] p;
    assign a  = opa[8*i +: 8];
    assign b  = src_b[8*i +: 8];
    assign s  = {1'b0, a} + {1'b0, b};
    assign d  = {1'b0, a} - {1'b0, b};
    assign s1 = s + 9'd1;
    assign p  = {8'd0, a} * {8'd0, b};
    always_comb begin
      case (opcode)
        OP_AND:  r = a & b;
        OP_NOR:  r = ~(a | b);
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SLL:  r = a << b[2:0];
        OP_SRL:  r = a >> b[2:0];
        OP_ADD:  r = s[8] ? 8'hFF : s[7:0];
        OP_SUB:  r = d[8] ? 8'h00 : d[7:0];
        OP_MIN:  r = (a < b) ? a : b;
        OP_MAX:  r = (a > b) ? a : b;
        OP_MUL:  r = (|p[15:8]) ? 8'hFF : p[7:0];
        OP_ABSD: r = (a >= b) ? a - b : b - a;
        OP_AVG:  r = s1[8:1];
        OP_PICK: r = (cond_q[i] == pick_tf) ? a : b;
        default: r = 8'h00;
      endcase
    end
    assign res_b[8*i +: 8] = r;
    assign flag_b[i] = (cmp_eq && (a == b)) || (cmp_lt && (a < b));
  end

  for (genvar i = 0; i < 4; i++) begin : g_half
    logic signed [15:0] a, b;
    logic        [15:0] r;
    logic signed [16:0] s, d;
    logic signed [31:0] p;
    assign a = opa[16*i +: 16];
    assign b = src_h[16*i +: 16];
    assign s = {a[15], a} + {b[15], b};
    assign d = {a[15], a} - {b[15], b};
    assign p = a * b;
    always_comb begin
      case (opcode)
        OP_AND:  r = a & b;
        OP_NOR:  r = ~(a | b);
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_SLL:  r = a << b[3:0];
        OP_SRL:  r = a >> b[3:0];
        OP_SRA:  r = a >>> b[3:0];
        OP_ADD:  r = (s[16] != s[15]) ? (s[16] ? 16'h8000 : 16'h7FFF) : s[15:0];
        OP_SUB:  r = (d[16] != d[15]) ? (d[16] ? 16'h8000 : 16'h7FFF) : d[15:0];
        OP_MIN:  r = (a < b) ? a : b;
        OP_MAX:  r = (a > b) ? a : b;
        OP_MUL:  r = (p > 32'sd32767) ? 16'h7FFF : (p < -32'sd32768) ? 16'h8000 : p[15:0];
        OP_SMUL: r = b[15] ? ((a == -16'sd32768) ? 16'h7FFF : -a) : a;
        OP_PICK: r = (cond_q[i] == pick_tf) ? a : b;
        default: r = 16'h0000;
      endcase
    end
    assign res_h[16*i +: 16] = r;
    assign flag_h[i] = (cmp_eq && (a == b)) || (cmp_lt && (a < b));
  end

  assign illegal = (opcode > OP_PICK) ||
                   (!half && (opcode == OP_SMUL || opcode == OP_SRA)) ||
                   (half && (opcode == OP_ABSD || opcode == OP_AVG));

  assign result = (illegal || opcode == OP_CMP) ? 64'd0 : (half ? res_h : res_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cond_q <= 8'd0;
    else if (op_en && opcode == OP_CMP) begin
      if (half) cond_q[3:0] <= flag_h;
      else      cond_q      <= flag_b;
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_en,
  input logic [4:0]  opcode,
  input logic        fmt_half,
  input logic [1:0]  fmt_src,
  input logic [7:0]  a_lo,
  input logic        pick_tf,
  input logic [7:0]  res_lo,
  input logic        res_zero,
  input logic [7:0]  cond_q,
  input logic        illegal
);
  assert_illegal_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> res_zero);

  assert_cond_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_en && opcode == 5'd15) |=> $stable(cond_q));

  assert_upper_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && opcode == 5'd15 && fmt_half) |=> cond_q[7:4] == $past(cond_q[7:4]));

  assert_add_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'd6 && !fmt_half) |-> res_lo >= a_lo);

  assert_pick_lane0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'd16 && !fmt_half && fmt_src == 2'b10 && cond_q[0] == pick_tf) |-> res_lo == a_lo);
endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_en(op_en), .opcode(opcode),
  .fmt_half(fmtsel[0]), .fmt_src(fmtsel[4:3]), .a_lo(opa[7:0]),
  .pick_tf(pick_tf), .res_lo(result[7:0]), .res_zero(result == 64'd0),
  .cond_q(cond_q), .illegal(illegal)
);

// File: tb/simd_sat_alu_test.sv
module simd_sat_alu_test;
  logic        clk = 0, rst_n = 0, op_en = 0;
  logic [4:0]  opcode = 0, fmtsel = 0, imm = 0;
  logic [63:0] opa = 0, opb = 0;
  logic        cmp_eq = 0, cmp_lt = 0, pick_tf = 0;
  logic [63:0] result;
  logic [7:0]  cond_q;
  logic        illegal;
  int checks = 0, fails = 0;

  localparam logic [4:0] BV = 5'b10000, HV = 5'b10001, BI = 5'b11000, HI = 5'b11001;

  simd_sat_alu uut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(logic [4:0] op, logic [4:0] fs, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    opcode = op; fmtsel = fs; opa = a; opb = b;
    #2;
  endtask

  task automatic compare(logic [4:0] fs, logic [63:0] a, logic [63:0] b, logic eq, logic lt, logic en);
    @(negedge clk);
    opcode = 5'd15; fmtsel = fs; opa = a; opb = b; cmp_eq = eq; cmp_lt = lt; op_en = en;
    #2 chk("R9 compare result", result, 64'd0);
    @(posedge clk); #2;
    op_en = 0;
  endtask

  task automatic t_reset;
    chk("R13 reset cond", {56'd0, cond_q}, 64'h0);
  endtask

  task automatic t_logic;
    run(0, BV, 64'hF0F0_0F0F_AAAA_5555, 64'hFF00_FF00_0F0F_F0F0); chk("R3 and", result, 64'hF000_0F00_0A0A_5050);
    run(1, BV, opa, opb); chk("R3 nor", result, 64'h000F_00F0_5050_0A0A);
    run(2, BV, opa, opb); chk("R3 or",  result, 64'hFFF0_FF0F_AFAF_F5F5);
    run(3, BV, opa, opb); chk("R3 xor", result, 64'h0FF0_F00F_A5A5_A5A5);
  endtask

  task automatic t_shift;
    imm = 5'd9;
    run(4, BI, 64'h8001_0203_4080_FF7F, 0); chk("R4 byte sll masked", result, 64'h0002_0406_8000_FEFE);
    imm = 5'd20;
    run(12, HI, 64'h8000_7FF0_FFF0_0123, 0); chk("R4 half sra masked", result, 64'hF800_07FF_FFFF_0012);
    run(5, HI, opa, 0); chk("R4 half srl", result, 64'h0800_07FF_0FFF_0012);
    run(12, BI, opa, 0);
    chk("R12 byte sra illegal", {63'd0, illegal}, 64'd1);
    chk("R12 byte sra zero", result, 64'd0);
  endtask

  task automatic t_addsub;
    run(6, BV, 64'hFF80_1000_057F_01C8, 64'h0180_2000_0301_0240); chk("R5 byte add", result, 64'hFFFF_3000_0880_03FF);
    run(7, BV, opa, opb); chk("R5 byte sub", result, 64'hFE00_0000_027E_0088);
    run(6, HV, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1111_0001); chk("R5 half add", result, 64'h7FFF_8000_2345_0000);
    run(7, HV, opa, opb); chk("R5 half sub", result, 64'h7FFE_8001_0123_FFFE);
    run(7, HV, 64'h8000_7FFF_0000_0000, 64'h0001_FFFF_0000_0000); chk("R5 half sub clamp", result, 64'h8000_7FFF_0000_0000);
  endtask

  task automatic t_mul;
    run(10, 5'b00100, 64'h0102_0F10_FF00_0803, 64'h0000_0000_0010_0000); chk("R6 byte mul elem", result, 64'h1020_F0FF_FF00_8030);
    run(10, HV, 64'h8000_0100_FFFF_0003, 64'h8000_FF00_0002_FFFE); chk("R6 half mul", result, 64'h7FFF_8000_FFFE_FFFA);
  endtask

  task automatic t_smul;
    run(11, HV, 64'h8000_1234_8000_0005, 64'hFFFF_FFFF_0001_0000); chk("R7 sign mul", result, 64'h7FFF_EDCC_8000_0005);
    run(11, BV, opa, opb); chk("R12 byte smul illegal", {63'd0, illegal}, 64'd1);
  endtask

  task automatic t_avgabs;
    run(14, BV, 64'hFF00_0310_807F_01FE, 64'hFF01_0420_7F80_0000); chk("R8 avg", result, 64'hFF01_0418_8080_017F);
    run(13, BV, opa, opb); chk("R8 absdiff", result, 64'h0001_0110_0101_01FE);
    run(14, HV, opa, opb);
    chk("R12 half avg illegal", {63'd0, illegal}, 64'd1);
    chk("R12 half avg zero", result, 64'd0);
  endtask

  task automatic t_minmax;
    run(8, HV, 64'h8000_7FFF_FFFF_0001, 64'h0001_0000_0001_FFFF); chk("R1 half min signed", result, 64'h8000_0000_FFFF_FFFF);
    run(9, HV, opa, opb); chk("R1 half max signed", result, 64'h0001_7FFF_0001_0001);
    run(8, BV, 64'h8000_7FFF_FFFF_0001, 64'h0100_0001_0001_FFFF); chk("R1 byte min unsigned", result, 64'h0100_0001_0001_0001);
  endtask

  task automatic t_source;
    run(6, 5'b01101, 64'h0001_0002_0003_0004, 64'h0007_0000_0000_0000); chk("R2 half elem", result, 64'h0008_0009_000A_000B);
    imm = 5'd31;
    run(6, HI, 64'h0001_FFFF_8000_7FFF, 64'hFFFF_FFFF_FFFF_FFFF); chk("R2 half imm", result, 64'h0020_001E_801F_7FFF);
  endtask

  task automatic t_cmp_pick;
    compare(BV, 64'h0105_FF80_0010_2030, 64'h0104_0081_0011_202F, 1, 1, 1);
    chk("R9 byte cmp flags", {56'd0, cond_q}, 64'h9E);
    compare(HV, 64'h8000_0001_0005_FFFF, 64'h0000_0001_0004_0000, 0, 1, 1);
    chk("R10 half cmp keeps upper", {56'd0, cond_q}, 64'h99);
    compare(BV, 64'h0, 64'h0, 1, 0, 0);
    chk("R13 disabled cmp", {56'd0, cond_q}, 64'h99);
    @(negedge clk);
    opcode = 5'd20; op_en = 1;
    #2 chk("R12 code 20 zero", result, 64'd0);
    chk("R12 code 20 flag", {63'd0, illegal}, 64'd1);
    @(posedge clk); #2 op_en = 0;
    chk("R12 cond unchanged", {56'd0, cond_q}, 64'h99);
    pick_tf = 1;
    run(16, BV, 64'h1122_3344_5566_7788, 64'hAABB_CCDD_EEFF_0099); chk("R11 byte pick tf1", result, 64'h11BB_CC44_55FF_0088);
    pick_tf = 0; imm = 5'd5;
    run(16, BI, opa, opb); chk("R11 byte pick imm tf0", result, 64'h0522_3305_0566_7705);
    pick_tf = 1;
    run(16, HV, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD); chk("R11 half pick", result, 64'h1111_BBBB_CCCC_4444);
  endtask

  initial begin
    #45 rst_n = 1;
    t_reset();
    t_logic();
    t_shift();
    t_addsub();
    t_mul();
    t_smul();
    t_avgabs();
    t_minmax();
    t_source();
    t_cmp_pick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule